// File: doc/BRIEF.md
# Single-Line Serial Bus Master

This block drives a shared, open-drain, half-duplex serial line on which the master starts every exchange. A host hands it one command at a time: bus reset, write one byte, read one byte, or send a 64-bit device identifier. The engine turns each command into a train of fixed-length time slots, and it times every slot in microseconds from a clock-enable tick that it derives from the system clock.

The line is modelled as open drain. The engine only ever asserts `lineDrvLow` to pull the wire to 0 and otherwise releases it, and it reads the resolved level back on `lineIn`. A bus reset reports whether any device answered. A read returns the assembled byte. Sending an identifier also runs an 8-bit CRC over the 64 bits and reports whether the identifier is self-consistent.

Top module: `wbm_top`

## Requirements
- R1: After reset, `busy`, `done`, `lineDrvLow`, `presence` and `crcOk` are all 0.
- R2: A reset command (cmdOp=0) pulls the line low for 480 µs, then releases it for a further 480 µs, and then completes.
- R3: 70 µs after the reset low is released, the line is sampled. `presence` becomes 1 if the line is low at that moment and 0 if it is high.
- R4: Each bit occupies a 60 µs slot followed by 2 µs of release. A 1 is written as a 6 µs low pulse. A 0 is written as low for the whole 60 µs slot. A read slot starts with a 6 µs low pulse.
- R5: A write-byte command (cmdOp=1) sends `cmdData` as 8 slots, least significant bit first.
- R6: A read-byte command (cmdOp=2) runs 8 read slots and samples the line 15 µs after each slot starts. A high line is a 1. The bits are assembled least significant bit first into `rdData`.
- R7: A send-identifier command (cmdOp=3) sends all 64 bits of `cmdId` as write slots, bit 0 first. Bits [7:0] are the family code, bits [55:8] the serial number and bits [63:56] the check byte.
- R8: During a send-identifier command, a CRC with polynomial x^8+x^5+x^4+1 runs over the sent bits, least significant bit first, starting from zero. When the command ends, `crcOk` is 1 if the remainder is zero and 0 otherwise.
- R9: `busy` stays high from command acceptance to completion. `done` pulses for exactly one cycle at completion. A `cmdValid` raised while `busy` is high has no effect.
- R10: While the engine is idle, the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmdValid | input | 1 | Command request; taken only while idle |
| cmdOp | input | 2 | 0 reset, 1 write byte, 2 read byte, 3 send identifier |
| cmdData | input | 8 | Byte to write |
| cmdId | input | 64 | Identifier to send, bit 0 goes first |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion strobe |
| rdData | output | 8 | Byte assembled by the last read |
| presence | output | 1 | A device answered the last reset |
| crcOk | output | 1 | Last identifier had a zero CRC remainder |
| lineIn | input | 1 | Resolved level of the shared line |
| lineDrvLow | output | 1 | 1 pulls the line low, 0 releases it |

## Verification
Some properties hold on every cycle, and embedded assertions check them there. The line is never pulled while idle. `done` is a lone pulse and coincides with the end of `busy`. No low pulse outlasts the reset width. The microsecond tick never fires twice in a row. Every shift has a bit left to move. `crcOk` only rises during an identifier transfer.

Other behaviour needs a modelled device on the wire, so only the bench scenarios can show it. These scenarios measure the pulse widths per bit and decode the bit order seen on the wire. They also confirm that the presence answer is or is not detected, that the bytes driven by the device are assembled correctly, that good and corrupted identifiers give the right CRC verdict, and that a command issued mid-transfer is dropped.

// File: rtl/wbm_pkg.sv
`timescale 1ns/1ps
package wbm_pkg;
  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_ID    = 2'd3
  } wbm_op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic sampleBit;
    logic samplePres;
    logic shift;
  } wbm_strobe_t;

  localparam int ID_BITS   = 64;
  localparam int BYTE_BITS = 8;
  localparam logic [7:0] CRC_POLY_REFL = 8'h8C;
endpackage

// File: rtl/wbm_tick.sv
`timescale 1ns/1ps
module wbm_tick #(
  parameter int CLK_PER_US = 200
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int W = $clog2(CLK_PER_US + 1);
  localparam logic [W-1:0] LAST = W'(CLK_PER_US - 1);

  logic [W-1:0] divCnt;

  always_ff @(posedge clk) begin
    if (rst) divCnt <= '0;
    else if (divCnt == LAST) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  assign tick = (divCnt == LAST);

  generate
    if (CLK_PER_US > 1) begin : g_spacing
      assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/wbm_datapath.sv
`timescale 1ns/1ps
module wbm_datapath
  import wbm_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  wbm_strobe_t   stb,
  input  wbm_op_e       cmdOp,
  input  logic [7:0]    cmdData,
  input  logic [63:0]   cmdId,
  input  logic          lineIn,
  output logic          longLow,
  output logic          bitsDone,
  output logic [7:0]    rdData,
  output logic          presence,
  output logic          crcOk
);
  localparam int CNT_W = $clog2(ID_BITS + 1);

  logic [1:0]         lineSync;
  logic [ID_BITS-1:0] shiftQ;
  logic [CNT_W-1:0]   bitsLeft;
  logic               readBitQ;
  wbm_op_e            opQ;
  logic [7:0]         crcQ, crcNext, rdQ;
  logic               presQ, crcOkQ, bitNow;

  assign bitNow  = (opQ == OP_READ) ? readBitQ : shiftQ[0];
  assign crcNext = {1'b0, crcQ[7:1]} ^ ((crcQ[0] ^ bitNow) ? CRC_POLY_REFL : 8'h00);

  always_ff @(posedge clk) begin
    if (rst) begin
      lineSync <= 2'b11;
      shiftQ   <= '0;
      bitsLeft <= '0;
      readBitQ <= 1'b1;
      opQ      <= OP_RESET;
      crcQ     <= '0;
      rdQ      <= '0;
      presQ    <= 1'b0;
      crcOkQ   <= 1'b0;
    end else begin
      lineSync <= {lineSync[0], lineIn};
      if (stb.load) begin
        opQ <= cmdOp;
        shiftQ <= (cmdOp == OP_ID) ? cmdId : ID_BITS'(cmdData);
        case (cmdOp)
          OP_ID:    bitsLeft <= CNT_W'(ID_BITS);
          OP_RESET: bitsLeft <= '0;
          default:  bitsLeft <= CNT_W'(BYTE_BITS);
        endcase
        if (cmdOp == OP_ID) begin
          crcQ   <= '0;
          crcOkQ <= 1'b0;
        end
      end
      if (stb.samplePres) presQ <= !lineSync[1];
      if (stb.sampleBit) readBitQ <= lineSync[1];
      if (stb.shift) begin
        shiftQ   <= {1'b0, shiftQ[ID_BITS-1:1]};
        bitsLeft <= bitsLeft - 1'b1;
        if (opQ == OP_READ) rdQ <= {bitNow, rdQ[7:1]};
        if (opQ == OP_ID) begin
          crcQ <= crcNext;
          if (bitsLeft == CNT_W'(1)) crcOkQ <= (crcNext == 8'h00);
        end
      end
    end
  end

  assign longLow  = (opQ == OP_WRITE || opQ == OP_ID) && !shiftQ[0];
  assign bitsDone = (bitsLeft == '0);
  assign rdData   = rdQ;
  assign presence = presQ;
  assign crcOk    = crcOkQ;

  assert_shift_has_bits_R5: assert property (@(posedge clk) disable iff (rst)
    stb.shift |-> bitsLeft != '0);
  assert_crc_flag_from_id_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(crcOkQ) |-> opQ == OP_ID);
endmodule

// File: rtl/wbm_ctrl.sv
`timescale 1ns/1ps
module wbm_ctrl
  import wbm_pkg::*;
#(
  parameter int CLK_PER_US  = 200,
  parameter int T_RST_LOW   = 480,
  parameter int T_PRES      = 70,
  parameter int T_RST_TOTAL = 960,
  parameter int T_SLOT      = 60,
  parameter int T_LOW       = 6,
  parameter int T_RDSAMP    = 15,
  parameter int T_REC       = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        cmdValid,
  input  wbm_op_e     cmdOp,
  input  logic        longLow,
  input  logic        bitsDone,
  output wbm_strobe_t stb,
  output logic        busy,
  output logic        done,
  output logic        lineDrvLow
);
  localparam int US_W = $clog2(T_RST_TOTAL + 1);
  localparam logic [US_W-1:0] L_RST_LOW  = US_W'(T_RST_LOW);
  localparam logic [US_W-1:0] L_PRES     = US_W'(T_RST_LOW + T_PRES);
  localparam logic [US_W-1:0] L_RST_END  = US_W'(T_RST_TOTAL - 1);
  localparam logic [US_W-1:0] L_SLOT     = US_W'(T_SLOT);
  localparam logic [US_W-1:0] L_SLOT_END = US_W'(T_SLOT - 1);
  localparam logic [US_W-1:0] L_LOW      = US_W'(T_LOW);
  localparam logic [US_W-1:0] L_RDSAMP   = US_W'(T_RDSAMP);
  localparam logic [US_W-1:0] L_REC_END  = US_W'(T_REC - 1);
  localparam int LOW_MAX = (T_RST_LOW + 1) * CLK_PER_US;

  typedef enum logic [1:0] {S_IDLE, S_RST, S_SLOT, S_REC} state_e;

  state_e          stateQ;
  logic [US_W-1:0] usCnt;
  logic            doneQ, drvQ, drvComb;
  logic [31:0]     lowRun;

  always_comb begin
    stb.load       = (stateQ == S_IDLE) && cmdValid;
    stb.sampleBit  = (stateQ == S_SLOT) && tick && (usCnt == L_RDSAMP);
    stb.samplePres = (stateQ == S_RST) && tick && (usCnt == L_PRES);
    stb.shift      = (stateQ == S_SLOT) && tick && (usCnt == L_SLOT_END);
    drvComb = ((stateQ == S_RST) && (usCnt < L_RST_LOW)) ||
              ((stateQ == S_SLOT) && (usCnt < (longLow ? L_SLOT : L_LOW)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= S_IDLE;
      usCnt  <= '0;
      doneQ  <= 1'b0;
      drvQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      drvQ  <= drvComb;
      case (stateQ)
        S_IDLE: if (cmdValid) begin
          stateQ <= (cmdOp == OP_RESET) ? S_RST : S_SLOT;
          usCnt  <= '0;
        end
        S_RST: if (tick) begin
          if (usCnt == L_RST_END) begin
            stateQ <= S_IDLE;
            doneQ  <= 1'b1;
          end else usCnt <= usCnt + 1'b1;
        end
        S_SLOT: if (tick) begin
          if (usCnt == L_SLOT_END) begin
            stateQ <= S_REC;
            usCnt  <= '0;
          end else usCnt <= usCnt + 1'b1;
        end
        default: if (tick) begin
          if (usCnt == L_REC_END) begin
            usCnt <= '0;
            if (bitsDone) begin
              stateQ <= S_IDLE;
              doneQ  <= 1'b1;
            end else stateQ <= S_SLOT;
          end else usCnt <= usCnt + 1'b1;
        end
      endcase
    end
  end

  assign busy       = (stateQ != S_IDLE);
  assign done       = doneQ;
  assign lineDrvLow = drvQ;

  // length of the current low drive, for the pulse-width bound
  always_ff @(posedge clk) begin
    if (rst) lowRun <= '0;
    else lowRun <= drvQ ? lowRun + 1 : '0;
  end

  assert_idle_released_R10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !lineDrvLow);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_ends_busy_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_low_bounded_R2: assert property (@(posedge clk) disable iff (rst)
    lowRun <= 32'(LOW_MAX));
endmodule

// File: rtl/wbm_top.sv
`timescale 1ns/1ps
module wbm_top
  import wbm_pkg::*;
#(
  parameter int CLK_PER_US = 200
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmdValid,
  input  logic [1:0]  cmdOp,
  input  logic [7:0]  cmdData,
  input  logic [63:0] cmdId,
  output logic        busy,
  output logic        done,
  output logic [7:0]  rdData,
  output logic        presence,
  output logic        crcOk,
  input  logic        lineIn,
  output logic        lineDrvLow
);
  wbm_strobe_t stb;
  wbm_op_e     opEnum;
  logic        tick, longLow, bitsDone;

  assign opEnum = wbm_op_e'(cmdOp);

  wbm_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .rst(rst), .tick(tick));

  wbm_ctrl #(.CLK_PER_US(CLK_PER_US)) u_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .cmdValid(cmdValid), .cmdOp(opEnum),
    .longLow(longLow), .bitsDone(bitsDone), .stb(stb), .busy(busy),
    .done(done), .lineDrvLow(lineDrvLow));

  wbm_datapath u_dp (
    .clk(clk), .rst(rst), .stb(stb), .cmdOp(opEnum), .cmdData(cmdData),
    .cmdId(cmdId), .lineIn(lineIn), .longLow(longLow), .bitsDone(bitsDone),
    .rdData(rdData), .presence(presence), .crcOk(crcOk));
endmodule

// File: tb/wbm_top_bench.sv
`timescale 1ns/1ps
module wbm_top_bench;
  localparam int CPU = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'd0;
  logic [7:0] cmdData = 8'h00;
  logic [63:0] cmdId = '0;
  logic busy, done, presence, crcOk, lineDrvLow;
  logic [7:0] rdData;
  logic slaveLow = 1'b0;
  logic lineWire;

  int total = 0, bad = 0;

  // device model state
  logic slavePresent = 1'b1;
  logic slaveReadMode = 1'b0;
  logic [7:0] slaveByte = 8'h00;
  logic [2:0] slaveIdx = '0;

  // wire monitor records
  int   capIdx = 0;
  int   capLen [64];
  logic capBit [64];
  int   busyCycles = 0;

  assign lineWire = !(lineDrvLow || slaveLow);

  always #2.5 clk = ~clk;

  wbm_top #(.CLK_PER_US(CPU)) u_wbm_top (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdData(cmdData), .cmdId(cmdId), .busy(busy), .done(done),
    .rdData(rdData), .presence(presence), .crcOk(crcOk),
    .lineIn(lineWire), .lineDrvLow(lineDrvLow));

  // device on the wire: presence answer and read-slot data
  initial begin
    forever begin
      int n;
      @(posedge lineDrvLow);
      n = 0;
      while (lineDrvLow) begin @(negedge clk); n++; end
      if (n >= 400 * CPU) begin
        if (slavePresent) begin
          repeat (20 * CPU) @(negedge clk);
          slaveLow = 1'b1;
          repeat (120 * CPU) @(negedge clk);
          slaveLow = 1'b0;
        end
      end else if (slaveReadMode) begin
        if (!slaveByte[slaveIdx]) begin
          slaveLow = 1'b1;
          repeat (35 * CPU) @(negedge clk);
          slaveLow = 1'b0;
        end
        slaveIdx = slaveIdx + 3'd1;
      end
    end
  end

  // master pulse monitor: low length and level 30 us after the fall
  initial begin
    forever begin
      int c, len;
      logic lenDone, bitv;
      @(posedge lineDrvLow);
      c = 0; len = 0; lenDone = 1'b0; bitv = 1'b0;
      forever begin
        @(negedge clk);
        c++;
        if (!lineDrvLow && !lenDone) begin len = c - 1; lenDone = 1'b1; end
        if (c == 30 * CPU) bitv = lineWire;
        if (lenDone && c >= 30 * CPU) break;
      end
      if (capIdx < 64) begin
        capLen[capIdx] = len;
        capBit[capIdx] = bitv;
      end
      capIdx++;
    end
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] crc8(input logic [55:0] d);
    logic [7:0] c;
    c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      logic fb;
      fb = c[0] ^ d[i];
      c = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  task automatic startCmd(input logic [1:0] op, input logic [7:0] d, input logic [63:0] id);
    @(negedge clk);
    cmdOp = op; cmdData = d; cmdId = id; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitDone();
    busyCycles = 0;
    while (!done) begin
      if (busy) busyCycles++;
      @(negedge clk);
    end
  endtask

  task automatic runCmd(input logic [1:0] op, input logic [7:0] d, input logic [63:0] id);
    capIdx = 0;
    startCmd(op, d, id);
    waitDone();
    @(negedge clk);
    chk(done == 1'b0, "R9", "done lasts one cycle", done, 0);
    chk(lineDrvLow == 1'b0, "R10", "line released when idle", lineDrvLow, 0);
  endtask

  function automatic logic inWin(input int act, input int us);
    return (act > (us - 1) * CPU) && (act <= us * CPU);
  endfunction

  task automatic test_reset_state();
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    chk(lineDrvLow == 1'b0, "R1", "line drive after reset", lineDrvLow, 0);
    chk(presence == 1'b0, "R1", "presence after reset", presence, 0);
    chk(crcOk == 1'b0, "R1", "crcOk after reset", crcOk, 0);
  endtask

  task automatic test_bus_reset(input logic present);
    slavePresent = present;
    slaveReadMode = 1'b0;
    runCmd(2'd0, 8'h00, '0);
    chk(capIdx == 1, "R2", "one low pulse per reset", capIdx, 1);
    chk(inWin(capLen[0], 480), "R2", "reset low length (cycles)", capLen[0], 480 * CPU);
    chk(busyCycles > 959 * CPU && busyCycles <= 960 * CPU, "R2", "reset total busy cycles",
        busyCycles, 960 * CPU);
    chk(presence == present, "R3", "presence flag", presence, present);
  endtask

  task automatic test_write_byte(input logic [7:0] b);
    slaveReadMode = 1'b0;
    runCmd(2'd1, b, '0);
    chk(capIdx == 8, "R5", "slot count", capIdx, 8);
    chk(busyCycles > 495 * CPU && busyCycles <= 496 * CPU, "R9", "busy cycles for a byte",
        busyCycles, 496 * CPU);
    for (int i = 0; i < 8; i++) begin
      chk(capBit[i] == b[i], "R5", $sformatf("bit %0d on wire", i), capBit[i], b[i]);
      chk(inWin(capLen[i], b[i] ? 6 : 60), "R4", $sformatf("low width bit %0d", i),
          capLen[i], (b[i] ? 6 : 60) * CPU);
    end
  endtask

  task automatic test_read_byte(input logic [7:0] b);
    slaveByte = b; slaveIdx = '0; slaveReadMode = 1'b1;
    runCmd(2'd2, 8'h00, '0);
    slaveReadMode = 1'b0;
    chk(rdData == b, "R6", "read byte", rdData, b);
    chk(capIdx == 8, "R6", "read slot count", capIdx, 8);
    for (int i = 0; i < 8; i++)
      chk(inWin(capLen[i], 6), "R4", $sformatf("read slot low width %0d", i), capLen[i], 6 * CPU);
  endtask

  task automatic test_send_id(input logic [55:0] body, input logic corrupt);
    logic [63:0] id;
    logic [7:0] c;
    c = crc8(body);
    if (corrupt) c = c ^ 8'h10;
    id = {c, body};
    slaveReadMode = 1'b0;
    runCmd(2'd3, 8'h00, id);
    chk(capIdx == 64, "R7", "identifier slot count", capIdx, 64);
    for (int i = 0; i < 64; i++)
      if (i < capIdx) chk(capBit[i] == id[i], "R7", $sformatf("id bit %0d", i), capBit[i], id[i]);
    chk(crcOk == !corrupt, "R8", "crcOk verdict", crcOk, !corrupt);
  endtask

  task automatic test_busy_ignore();
    slaveReadMode = 1'b0;
    capIdx = 0;
    startCmd(2'd1, 8'hFF, '0);
    repeat (50 * CPU) @(negedge clk);
    cmdOp = 2'd0; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    chk(busy == 1'b1, "R9", "busy held mid-transfer", busy, 1);
    waitDone();
    repeat (600 * CPU) @(negedge clk);
    chk(capIdx == 8, "R9", "no extra slots from ignored command", capIdx, 8);
    for (int i = 0; i < 8; i++)
      chk(inWin(capLen[i], 6), "R9", $sformatf("ignored cmd left bit %0d as 1", i),
          capLen[i], 6 * CPU);
    chk(busy == 1'b0, "R10", "idle after drop", busy, 0);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset_state();
    test_bus_reset(1'b1);
    test_bus_reset(1'b0);
    test_write_byte(8'hA5);
    test_write_byte(8'h3C);
    test_read_byte(8'h5A);
    test_read_byte(8'hC3);
    test_send_id(56'h1E_3A_77_00_91_C4_28, 1'b0);
    test_send_id(56'h1E_3A_77_00_91_C4_28, 1'b1);
    test_busy_ignore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule